// File: doc/BRIEF.md
# Programmable Envelope Shape Generator

The block produces a 5-bit amplitude envelope for a tone synthesiser. A 32-step up/down ramp counter advances once per step tick. A prescaler and a period divider derive that tick from the master clock, set by a 16-bit period value. A 4-bit shape code sets how the ramp behaves: its starting direction, whether it continues past the first cycle, whether it reverses direction, and whether it freezes. The level output feeds every channel that runs in variable-level mode.

Writing the shape is signalled by a one-cycle strobe. The strobe captures the new code and restarts both the ramp and the tick divider. The period is read live on every cycle and is not captured.

Top module: `env_shaper`

## Requirements
- R1: After reset the level is 31, and the block behaves as if shape code 0000 had just been written.
- R2: The level takes one step every 16 × EP master-clock cycles, counted from the cycle of the last shape write.
- R3: A period value EP of 0 gives the same step timing as EP = 1.
- R4: The shape code is bit 3 = continue, bit 2 = attack, bit 1 = alternate, bit 0 = hold. A strobe on `shape_wr_i` restarts the pattern and the divider. The level on the next cycle is 0 when attack = 1, or 31 when attack = 0. A write that lands on the same cycle as a step tick takes precedence over the tick.
- R5: With attack = 1, the first cycle rises by one per step, from 0 to 31.
- R6: With attack = 0, the first cycle falls by one per step, from 31 to 0.
- R7: With continue = 0, the level is 0 from step 32 onward and stays there, whatever alternate and hold are set to.
- R8: With continue = 1, hold = 1 and alternate = 0, the level freezes at the final value of the first cycle.
- R9: With continue = 1, hold = 1 and alternate = 1, the level freezes at the extreme opposite to the final value of the first cycle.
- R10: With continue = 1, hold = 0 and alternate = 0, the same ramp repeats. The level jumps between 31 and 0 at each cycle boundary.
- R11: With continue = 1, hold = 0 and alternate = 1, the direction reverses each cycle. The extreme value is kept for two consecutive steps.
- R12: When no write occurs, the level either stays unchanged or moves by exactly one, or it moves between the two extremes 0 and 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | 16 | Envelope period value EP |
| shape_i | input | 4 | Shape code {continue, attack, alternate, hold} |
| shape_wr_i | input | 1 | One-cycle strobe that captures `shape_i` |
| level_o | output | 5 | Current envelope level |

## Verification
A shape write and a step tick can fall on the same clock edge. In that case the restart must win, and the tick must be lost rather than applied on top of the new start value. The bench provokes this by writing a sawtooth shape with EP = 1. Exactly 16 cycles later it writes a falling shape, so that the second strobe meets the first tick. It then judges two things. The level must be 31 right after that edge. The first decrement must arrive a full 16 cycles later and not earlier.

// File: rtl/env_shaper.sv
module env_shaper #(
  parameter int PERIOD_W = 16,
  parameter int PRE_DIV  = 16,
  parameter int LVL_W    = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [3:0]          shape_i,
  input  logic                shape_wr_i,
  output logic [LVL_W-1:0]    level_o
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [LVL_W-1:0] TOP = '1;

  logic [PRE_W-1:0]    pre_q;
  logic [PERIOD_W-1:0] per_q;
  logic [LVL_W-1:0]    cnt_q;
  logic                up_q, frz_q, cont_q, alt_q, hld_q;

  logic [PERIOD_W-1:0] ep_eff;
  logic                pre_end, per_end, tick, cyc_end;

  assign ep_eff  = (period_i == '0) ? PERIOD_W'(1) : period_i;
  assign pre_end = (pre_q == PRE_W'(PRE_DIV - 1));
  assign per_end = (per_q >= ep_eff - PERIOD_W'(1));
  assign tick    = pre_end && per_end;
  assign cyc_end = (cnt_q == TOP);
  assign level_o = up_q ? cnt_q : ~cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      per_q  <= '0;
      cnt_q  <= '0;
      up_q   <= 1'b0;
      frz_q  <= 1'b0;
      cont_q <= 1'b0;
      alt_q  <= 1'b0;
      hld_q  <= 1'b0;
    end else if (shape_wr_i) begin
      pre_q  <= '0;
      per_q  <= '0;
      cnt_q  <= '0;
      up_q   <= shape_i[2];
      frz_q  <= 1'b0;
      cont_q <= shape_i[3];
      alt_q  <= shape_i[1];
      hld_q  <= shape_i[0];
    end else begin
      pre_q <= pre_end ? '0 : pre_q + PRE_W'(1);
      if (pre_end)
        per_q <= per_end ? '0 : per_q + PERIOD_W'(1);
      if (tick && !frz_q) begin
        if (!cyc_end) begin
          cnt_q <= cnt_q + LVL_W'(1);
        end else if (!cont_q) begin
          up_q  <= 1'b0;
          frz_q <= 1'b1;
        end else if (hld_q) begin
          up_q  <= up_q ^ alt_q;
          frz_q <= 1'b1;
        end else begin
          cnt_q <= '0;
          up_q  <= up_q ^ alt_q;
        end
      end
    end
  end
endmodule

// File: rtl/env_shaper_chk.sv
module env_shaper_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       shape_i,
  input logic             shape_wr_i,
  input logic [LVL_W-1:0] level_o
);
  localparam logic [LVL_W-1:0] TOP = '1;

  // R1
  level_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(level_o));

  // R4
  restart_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shape_wr_i |=> (level_o == ($past(shape_i[2]) ? '0 : TOP)));

  // R12
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shape_wr_i |=> (level_o == $past(level_o)) ||
                    (level_o == $past(level_o) + LVL_W'(1)) ||
                    (level_o == $past(level_o) - LVL_W'(1)) ||
                    (level_o == '0 && $past(level_o) == TOP) ||
                    (level_o == TOP && $past(level_o) == '0));

  // R2
  step_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((level_o != $past(level_o)) && !$past(shape_wr_i)) |=>
      ((level_o == $past(level_o)) || $past(shape_wr_i)));
endmodule

bind env_shaper env_shaper_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .shape_i(shape_i),
  .shape_wr_i(shape_wr_i), .level_o(level_o)
);

// File: tb/env_shaper_tb.sv
module env_shaper_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] period = 16'd1;
  logic [3:0]  shape = 4'd0;
  logic        wr = 1'b0;
  logic [4:0]  level;
  int          errors = 0;
  int          checks = 0;
  int          ep = 1;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  env_shaper u_dut (
    .clk(clk), .rst_n(rst_n), .period_i(period),
    .shape_i(shape), .shape_wr_i(wr), .level_o(level)
  );

  task automatic chk(input string req, input logic [4:0] exp);
    checks++;
    if (level !== exp) begin
      errors++;
      $display("FAIL %s: level=%0d expected=%0d at %0t", req, level, exp, $time);
    end
  endtask

  task automatic wr_shape(input logic [3:0] s);
    @(negedge clk);
    shape = s;
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic steps(input int n);
    repeat (n * 16 * ep) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 reset level", 5'd31);
    steps(1);
    chk("R1 reset decays", 5'd30);
  endtask

  task automatic t_attack_once;
    wr_shape(4'b0100);
    chk("R4 attack start", 5'd0);
    steps(1);  chk("R5 first step", 5'd1);
    steps(30); chk("R5 top", 5'd31);
    steps(1);  chk("R7 drop to zero", 5'd0);
    steps(8);  chk("R7 stays zero", 5'd0);
  endtask

  task automatic t_decay_once;
    wr_shape(4'b0011);
    chk("R4 decay start", 5'd31);
    steps(5);  chk("R6 falling", 5'd26);
    steps(27); chk("R7 ignores alt/hold", 5'd0);
    steps(20); chk("R7 still zero", 5'd0);
  endtask

  task automatic t_saw;
    wr_shape(4'b1100);
    steps(31); chk("R10 peak", 5'd31);
    steps(1);  chk("R10 wrap", 5'd0);
    steps(1);  chk("R10 rise again", 5'd1);
  endtask

  task automatic t_triangle;
    wr_shape(4'b1110);
    steps(32); chk("R11 peak held", 5'd31);
    steps(1);  chk("R11 reversed", 5'd30);
    steps(31); chk("R11 floor held", 5'd0);
    steps(1);  chk("R11 rising again", 5'd1);
  endtask

  task automatic t_holds;
    wr_shape(4'b1101);
    steps(32); chk("R8 frozen top", 5'd31);
    steps(20); chk("R8 still top", 5'd31);
    wr_shape(4'b1111);
    steps(32); chk("R9 opposite floor", 5'd0);
    steps(10); chk("R9 still floor", 5'd0);
    wr_shape(4'b1011);
    steps(32); chk("R9 decay opposite top", 5'd31);
  endtask

  task automatic t_timing;
    period = 16'd3; ep = 3;
    wr_shape(4'b1100);
    repeat (47) @(negedge clk);
    chk("R2 before step", 5'd0);
    @(negedge clk);
    chk("R2 on step", 5'd1);
    period = 16'd0; ep = 1;
    wr_shape(4'b1100);
    repeat (15) @(negedge clk);
    chk("R3 before step", 5'd0);
    @(negedge clk);
    chk("R3 EP0 as 1", 5'd1);
    period = 16'd1;
  endtask

  task automatic t_collide;
    wr_shape(4'b1100);
    repeat (15) @(negedge clk);
    shape = 4'b0000;
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    chk("R4 write beats tick", 5'd31);
    repeat (15) @(negedge clk);
    chk("R4 divider restarted", 5'd31);
    @(negedge clk);
    chk("R2 first step after restart", 5'd30);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_attack_once();
    t_decay_once();
    t_saw();
    t_triangle();
    t_holds();
    t_timing();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: timeout");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule